// File: doc/BRIEF.md
# Continuous Reference-Gated Frequency Counter

This block measures the frequency of an unknown clock against a free-running reference clock. A counter in the reference domain cuts time into back-to-back sample windows of a fixed number of reference cycles. A counter in the measured-clock domain counts rising edges of the measured clock during each window.

At every window boundary the edge count is captured and the edge counter restarts in the same cycle. The captured word then crosses back into the reference domain as one unit. A host reads the result whenever it likes, with no handshake and no interrupt. Once the first clean window has been delivered, the result is never older than one window plus the synchronizer latency.

The block is intended for clock monitoring, where a register read at any time returns edges-per-window. Frequency is edges × f_ref / WINDOW_CYCLES.

Top module: `freq_meter`

## Requirements
- R1: Windows are exactly WINDOW_CYCLES reference cycles long and follow each other without a gap. The delivered count equals the number of measured-clock rising edges in one window, within ±1.
- R2: The window boundary enters the measured domain as a toggling flag. That flag passes through a SYNC_STAGES-flop synchronizer, and an edge detector turns it into a capture pulse that lasts exactly one measured-clock cycle.
- R3: Capture and restart happen in the same measured-clock cycle. The edge in that cycle is counted as the first edge of the new window, so no edge is lost or counted twice. Over N consecutive windows the delivered counts sum to the total number of edges, within ±1.
- R4: `freq_valid` is 0 from reset until the first complete window has been captured and transferred. The partial window that starts at reset is discarded. After that, `freq_valid` stays 1.
- R5: `freq_count` and `freq_ovf` change only on a transfer from the measured domain, and both change in the same cycle. Between transfers they hold steady, so a read never returns a mixed word.
- R6: The edge counter saturates at 2^COUNT_W−1 instead of wrapping. `freq_ovf` is 1 exactly when the delivered count reached that value, and 0 otherwise.
- R7: After the measured frequency changes, the result shows the new rate within three windows.
- R8: While reset is held and right after it, `freq_count` is 0, `freq_ovf` is 0 and `freq_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| meas_clk | input | 1 | Clock whose frequency is measured |
| meas_rst | input | 1 | Synchronous active-high reset, measured domain |
| freq_count | output | COUNT_W | Edges counted in the latest complete window |
| freq_ovf | output | 1 | Count saturated in the latest window |
| freq_valid | output | 1 | A complete window has been delivered |

## Verification
The hardest case to reach from the ports is an edge that falls on the capture cycle itself: a fault there loses or double-counts one edge per window, and a single reading hides it. The stimulus uses a measured period that does not divide the window (7 ns against a 500 ns window), so the boundary moves to a different edge phase in every window and readings alternate between 71 and 72. The bench samples at the same reference phase in seven consecutive windows and compares the sum to the exact total of 500. Saturation is reached by driving a 1 ns measured clock into an 8-bit counter.

// File: rtl/fm_pkg.sv
package fm_pkg;

    localparam int unsigned DEF_WINDOW_CYCLES = 1000;
    localparam int unsigned DEF_COUNT_W       = 16;
    localparam int unsigned DEF_SYNC_STAGES   = 2;

    // Action taken by the measured-domain edge counter in one cycle
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,  // saturated, no boundary
        ACT_COUNT   = 2'd1,  // count one edge
        ACT_ARM     = 2'd2,  // first boundary: drop partial window
        ACT_CAPTURE = 2'd3   // boundary: capture and restart
    } cnt_act_e;

    function automatic logic toggle_seen(input logic now_v, input logic prev_v);
        return now_v ^ prev_v;
    endfunction

endpackage

// File: rtl/fm_window_gen.sv
module fm_window_gen #(
    parameter int unsigned WINDOW_CYCLES = fm_pkg::DEF_WINDOW_CYCLES
) (
    input  logic clk,
    input  logic rst,
    output logic win_flag
);
    localparam int unsigned WIN_W = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
    localparam logic [WIN_W-1:0] LAST = WIN_W'(WINDOW_CYCLES - 1);

    logic [WIN_W-1:0] win_cnt;
    logic             at_end;

    assign at_end = (win_cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_cnt  <= '0;
            win_flag <= 1'b0;
        end else if (at_end) begin
            win_cnt  <= '0;
            win_flag <= ~win_flag;
        end else begin
            win_cnt  <= win_cnt + 1'b1;
        end
    end

    AST_WIN_FLIP_AT_END: assert property (@(posedge clk) disable iff (rst)
        (win_flag != $past(win_flag)) |-> ($past(win_cnt) == LAST)); // R1
    AST_WIN_RESTART: assert property (@(posedge clk) disable iff (rst)
        (win_flag != $past(win_flag)) |-> (win_cnt == '0)); // R1

endmodule

// File: rtl/fm_toggle_sync.sv
module fm_toggle_sync #(
    parameter int unsigned STAGES = fm_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_in,
    output logic pulse
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= tog_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], tog_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            last  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            last  <= chain[STAGES-1];
            pulse <= fm_pkg::toggle_seen(chain[STAGES-1], last);
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse); // R2

endmodule

// File: rtl/fm_edge_counter.sv
module fm_edge_counter #(
    parameter int unsigned COUNT_W = fm_pkg::DEF_COUNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               boundary,
    output logic [COUNT_W-1:0] hold_count,
    output logic               hold_ovf,
    output logic               hold_tog
);
    import fm_pkg::*;

    localparam logic [COUNT_W-1:0] CNT_MAX = '1;

    logic [COUNT_W-1:0] cnt;
    logic               armed;
    cnt_act_e           act;

    always_comb begin
        if (boundary)            act = armed ? ACT_CAPTURE : ACT_ARM;
        else if (cnt == CNT_MAX) act = ACT_HOLD;
        else                     act = ACT_COUNT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            armed      <= 1'b0;
            hold_count <= '0;
            hold_ovf   <= 1'b0;
            hold_tog   <= 1'b0;
        end else begin
            unique case (act)
                ACT_COUNT: cnt <= cnt + 1'b1;
                ACT_HOLD:  cnt <= cnt;
                ACT_ARM: begin
                    cnt   <= COUNT_W'(1);
                    armed <= 1'b1;
                end
                ACT_CAPTURE: begin
                    cnt        <= COUNT_W'(1);
                    hold_count <= cnt;
                    hold_ovf   <= (cnt == CNT_MAX);
                    hold_tog   <= ~hold_tog;
                end
                default: cnt <= cnt;
            endcase
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_MAX && !boundary) |=> (cnt == CNT_MAX)); // R6
    AST_RESTART_ONE: assert property (@(posedge clk) disable iff (rst)
        boundary |=> (cnt == COUNT_W'(1))); // R3
    AST_CAPTURE_OLD: assert property (@(posedge clk) disable iff (rst)
        (boundary && armed) |=> (hold_count == $past(cnt))); // R3

endmodule

// File: rtl/fm_result_port.sv
module fm_result_port #(
    parameter int unsigned COUNT_W = fm_pkg::DEF_COUNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [COUNT_W-1:0] in_count,
    input  logic               in_ovf,
    output logic [COUNT_W-1:0] out_count,
    output logic               out_ovf,
    output logic               out_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_count <= '0;
            out_ovf   <= 1'b0;
            out_valid <= 1'b0;
        end else if (load) begin
            out_count <= in_count;
            out_ovf   <= in_ovf;
            out_valid <= 1'b1;
        end
    end

    AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(out_count) && $stable(out_ovf))); // R5
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid); // R4
    AST_VALID_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> out_valid); // R4

endmodule

// File: rtl/freq_meter.sv
module freq_meter #(
    parameter int unsigned WINDOW_CYCLES = fm_pkg::DEF_WINDOW_CYCLES,
    parameter int unsigned COUNT_W       = fm_pkg::DEF_COUNT_W,
    parameter int unsigned SYNC_STAGES   = fm_pkg::DEF_SYNC_STAGES
) (
    input  logic               ref_clk,
    input  logic               ref_rst,
    input  logic               meas_clk,
    input  logic               meas_rst,
    output logic [COUNT_W-1:0] freq_count,
    output logic               freq_ovf,
    output logic               freq_valid
);
    logic               win_flag;
    logic               boundary;
    logic [COUNT_W-1:0] hold_count;
    logic               hold_ovf;
    logic               hold_tog;
    logic               load;

    fm_window_gen #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_window (
        .clk      (ref_clk),
        .rst      (ref_rst),
        .win_flag (win_flag)
    );

    fm_toggle_sync #(.STAGES(SYNC_STAGES)) u_to_meas (
        .clk    (meas_clk),
        .rst    (meas_rst),
        .tog_in (win_flag),
        .pulse  (boundary)
    );

    fm_edge_counter #(.COUNT_W(COUNT_W)) u_counter (
        .clk        (meas_clk),
        .rst        (meas_rst),
        .boundary   (boundary),
        .hold_count (hold_count),
        .hold_ovf   (hold_ovf),
        .hold_tog   (hold_tog)
    );

    fm_toggle_sync #(.STAGES(SYNC_STAGES)) u_to_ref (
        .clk    (ref_clk),
        .rst    (ref_rst),
        .tog_in (hold_tog),
        .pulse  (load)
    );

    fm_result_port #(.COUNT_W(COUNT_W)) u_result (
        .clk       (ref_clk),
        .rst       (ref_rst),
        .load      (load),
        .in_count  (hold_count),
        .in_ovf    (hold_ovf),
        .out_count (freq_count),
        .out_ovf   (freq_ovf),
        .out_valid (freq_valid)
    );

    AST_OVF_MEANS_MAX: assert property (@(posedge ref_clk) disable iff (ref_rst)
        freq_ovf |-> (freq_count == {COUNT_W{1'b1}})); // R6

endmodule

// File: tb/test_freq_meter.sv
`timescale 1ns/1ps
module test_freq_meter;
    localparam int unsigned WIN = 100;
    localparam int unsigned CW  = 8;
    localparam real         TREF = 5.0;

    logic          ref_clk = 1'b0;
    logic          meas_clk = 1'b0;
    logic          ref_rst = 1'b1;
    logic          meas_rst = 1'b1;
    logic [CW-1:0] freq_count;
    logic          freq_ovf;
    logic          freq_valid;
    real           meas_half = 5.0;
    int            n_checks = 0;
    int            n_errors = 0;
    bit            done = 1'b0;

    freq_meter #(.WINDOW_CYCLES(WIN), .COUNT_W(CW)) i_freq_meter (
        .ref_clk    (ref_clk),
        .ref_rst    (ref_rst),
        .meas_clk   (meas_clk),
        .meas_rst   (meas_rst),
        .freq_count (freq_count),
        .freq_ovf   (freq_ovf),
        .freq_valid (freq_valid)
    );

    always #(TREF / 2.0) ref_clk = ~ref_clk;

    initial begin
        #1.3;
        forever #(meas_half) meas_clk = ~meas_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ref(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    function automatic int expected_count();
        return int'((real'(WIN) * TREF) / (2.0 * meas_half));
    endfunction

    function automatic bit near(input int a, input int b);
        return (a - b <= 1) && (b - a <= 1);
    endfunction

    task automatic t_reset();
        wait_ref(10);
        chk(freq_count == 0, "R8 count in reset", int'(freq_count), 0);
        chk(freq_ovf == 0, "R8 ovf in reset", int'(freq_ovf), 0);
        chk(freq_valid == 0, "R8 valid in reset", int'(freq_valid), 0);
        ref_rst  = 1'b0;
        meas_rst = 1'b0;
        wait_ref(1);
        chk(freq_valid == 0 && freq_count == 0, "R8 after release",
            int'(freq_valid), 0);
    endtask

    task automatic t_first_window();
        wait_ref(150);
        chk(freq_valid == 0, "R4 valid low before first full window", int'(freq_valid), 0);
        wait_ref(90);
        chk(freq_valid == 1, "R4 valid after first full window", int'(freq_valid), 1);
        chk(near(int'(freq_count), expected_count()), "R1 count at 10ns",
            int'(freq_count), expected_count());
        chk(freq_ovf == 0, "R6 no overflow at 10ns", int'(freq_ovf), 0);
    endtask

    task automatic t_freq_change(input real half);
        meas_half = half;
        wait_ref(3 * WIN);
        chk(near(int'(freq_count), expected_count()), "R7 count after change",
            int'(freq_count), expected_count());
        chk(freq_ovf == 0, "R6 ovf clear below max", int'(freq_ovf), 0);
        chk(freq_valid == 1, "R4 valid stays high", int'(freq_valid), 1);
    endtask

    task automatic t_boundary_sum();
        int sum;
        int changes;
        logic [CW-1:0] prev;
        meas_half = 3.5;
        wait_ref(3 * WIN + 37);
        sum = 0;
        for (int w = 0; w < 7; w++) begin
            chk(freq_count == 71 || freq_count == 72, "R3 per-window count",
                int'(freq_count), 71);
            sum += int'(freq_count);
            changes = 0;
            prev = freq_count;
            for (int c = 0; c < WIN; c++) begin
                @(negedge ref_clk);
                if (freq_count != prev) changes++;
                prev = freq_count;
            end
            chk(changes <= 1, "R5 one update per window", changes, 1);
        end
        chk(sum >= 499 && sum <= 501, "R3 R2 edges over seven windows", sum, 500);
    endtask

    task automatic t_saturate();
        meas_half = 0.5;
        wait_ref(3 * WIN);
        chk(freq_count == 255, "R6 saturated count", int'(freq_count), 255);
        chk(freq_ovf == 1, "R6 overflow flag", int'(freq_ovf), 1);
        meas_half = 5.0;
        wait_ref(3 * WIN);
        chk(freq_ovf == 0, "R6 overflow clears", int'(freq_ovf), 0);
        chk(freq_count == 50, "R7 recovery to 10ns", int'(freq_count), 50);
    endtask

    initial begin
        t_reset();
        t_first_window();
        t_freq_change(2.5);
        t_freq_change(10.0);
        t_boundary_sum();
        t_saturate();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(TREF * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule